// File: doc/BRIEF.md
# Output Voltage Fault Supervisor

This block supervises one switching-regulator output in the digital domain. Four analog comparators report the sensed output against fractions of its setpoint: below 75 %, below 90 %, above 110 % and above 120 %. Each of these flags is debounced for about 2 µs. The debounce length is a count of system clocks worked out from the clock frequency. The supervisor also reads a soft-start-done flag, an over-temperature flag, the enable input and a supply-lockout flag. The lockout flag already carries the hysteresis between the rising and falling supply thresholds.

From these inputs it drives four outputs:
- a power-good indication;
- a request that forces the low-side switch on, which acts as a soft crowbar while the output is too high;
- a shutdown output that switches the converter off;
- a one-clock pulse that asks the soft-start circuit to begin a full new ramp every time the converter leaves the off state.

The over-voltage response does not latch. The under-voltage response latches, but it is armed only after soft-start has completed. The latch clears only when enable goes low or the supply lockout asserts. The thermal shutdown holds for as long as its flag is high. The rising edge of that flag is not remembered.

Top module: `vfault_supervisor`

## Requirements
- R1: A comparator flag takes effect only after its raw value has differed from the filtered value on FILT_CNT consecutive clock samples. FILT_CNT equals the clock in MHz times FILT_NS, divided by 1000 and rounded up. A shorter excursion leaves every output unchanged.
- R2: `pwr_good` is high one clock after `ss_done` is high, the converter is on, and both the filtered below-90 % and filtered above-110 % flags are clear. Otherwise it is low.
- R3: `crowbar_lo` follows the filtered above-120 % flag one clock later and has no memory. It is held low while `supply_low` is high.
- R4: The filtered below-75 % flag sets a fault latch when `en` is high, `ss_done` is high, `supply_low` is low and `ot_hot` is low. `shutdown` then goes high on the next clock. It stays high after the flag clears or `ss_done` falls.
- R5: A filtered below-75 % flag while `ss_done` is low does not set the latch.
- R6: Driving `en` low or `supply_low` high clears the fault latch. `shutdown` drops one clock after both have returned to their active levels.
- R7: `ot_hot` high drives `shutdown` high on the next clock. `shutdown` releases one clock after `ot_hot` falls, and a restart pulse follows.
- R8: `ss_restart` is high for exactly one clock, on the clock where `shutdown` goes from high to low.
- R9: While `rst_n` is low, `shutdown` is high and `pwr_good`, `crowbar_lo` and `ss_restart` are low.
- R10: `shutdown` is high one clock after `en` is low or `supply_low` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| supply_low | input | 1 | Supply lockout active (hysteresis applied outside) |
| ot_hot | input | 1 | Over-temperature flag (hysteresis applied outside) |
| ss_done | input | 1 | Soft-start complete |
| v_below75 | input | 1 | Raw comparator: output under 75 % of setpoint |
| v_below90 | input | 1 | Raw comparator: output under 90 % of setpoint |
| v_above110 | input | 1 | Raw comparator: output over 110 % of setpoint |
| v_above120 | input | 1 | Raw comparator: output over 120 % of setpoint |
| pwr_good | output | 1 | Output in window and converter running |
| crowbar_lo | output | 1 | Force low-side switch on |
| shutdown | output | 1 | Converter off |
| ss_restart | output | 1 | One-clock request for a new soft-start |

## Verification
A debounce counter that is stuck or off by one moves the edge of `pwr_good` or `crowbar_lo` by at least one clock. The per-clock reference comparison exposes this within FILT_CNT+1 clocks of the comparator step. A fault latch that is lost or never set shows as `shutdown` returning low one clock after the below-75 % flag clears. A latch that sets too early shows as `shutdown` rising during a ramp while `ss_done` is low. Errors in the off-to-on edge detection appear as a missing or doubled `ss_restart` pulse. These show up in the cycle that `shutdown` falls, and the bench's running pulse count also catches them.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

   localparam int unsigned NUM_FLAGS = 4;

   // index of each comparator flag in the packed flag vector
   typedef enum int unsigned {
      FLG_UV75  = 0,
      FLG_LO90  = 1,
      FLG_HI110 = 2,
      FLG_OV120 = 3
   } flag_idx_e;

   // clocks needed to cover a window in ns, rounded up
   function automatic int unsigned window_clocks(int unsigned clk_mhz, int unsigned win_ns);
      return (clk_mhz * win_ns + 999) / 1000;
   endfunction

endpackage

// File: rtl/vfs_glitch_filter.sv
module vfs_glitch_filter #(
   parameter int unsigned COUNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);

   localparam int unsigned CW   = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clean <= 1'b0;
         run_q <= '0;
      end else if (raw == clean) begin
         run_q <= '0;
      end else if (run_q == LAST) begin
         clean <= raw;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

endmodule

// File: rtl/vfs_fault_ctl.sv
module vfs_fault_ctl
   import vfs_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 supply_low,
   input  logic                 ot_hot,
   input  logic                 ss_done,
   input  logic [NUM_FLAGS-1:0] filt,
   output logic                 pwr_good,
   output logic                 crowbar_lo,
   output logic                 shutdown,
   output logic                 ss_restart
);

   logic uv_latch_q;
   logic uv_latch_d;
   logic cut_off;
   logic arm;

   always_comb begin
      arm = en & ss_done & ~supply_low & ~ot_hot;
      if (!en || supply_low)
         uv_latch_d = 1'b0;
      else
         uv_latch_d = uv_latch_q | (arm & filt[FLG_UV75]);
      cut_off = uv_latch_d | ot_hot | supply_low | ~en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_latch_q <= 1'b0;
         shutdown   <= 1'b1;
         pwr_good   <= 1'b0;
         crowbar_lo <= 1'b0;
         ss_restart <= 1'b0;
      end else begin
         uv_latch_q <= uv_latch_d;
         shutdown   <= cut_off;
         pwr_good   <= ss_done & ~cut_off & ~filt[FLG_LO90] & ~filt[FLG_HI110];
         crowbar_lo <= filt[FLG_OV120] & ~supply_low;
         ss_restart <= shutdown & ~cut_off;
      end
   end

endmodule

// File: rtl/vfault_supervisor.sv
module vfault_supervisor
   import vfs_pkg::*;
#(
   parameter int unsigned CLK_MHZ = 50,
   parameter int unsigned FILT_NS = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic supply_low,
   input  logic ot_hot,
   input  logic ss_done,
   input  logic v_below75,
   input  logic v_below90,
   input  logic v_above110,
   input  logic v_above120,
   output logic pwr_good,
   output logic crowbar_lo,
   output logic shutdown,
   output logic ss_restart
);

   localparam int unsigned FILT_CNT = window_clocks(CLK_MHZ, FILT_NS);

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("vfault_supervisor: CLK_MHZ must be at least 1");
   end
   if (FILT_CNT < 2) begin : g_bad_filt
      $error("vfault_supervisor: filter window shorter than two clocks");
   end

   logic [NUM_FLAGS-1:0] raw_flags;
   logic [NUM_FLAGS-1:0] filt_flags;

   assign raw_flags[FLG_UV75]  = v_below75;
   assign raw_flags[FLG_LO90]  = v_below90;
   assign raw_flags[FLG_HI110] = v_above110;
   assign raw_flags[FLG_OV120] = v_above120;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filt
      vfs_glitch_filter #(.COUNT(FILT_CNT)) i_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_flags[g]),
         .clean (filt_flags[g])
      );
   end

   vfs_fault_ctl i_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .supply_low (supply_low),
      .ot_hot     (ot_hot),
      .ss_done    (ss_done),
      .filt       (filt_flags),
      .pwr_good   (pwr_good),
      .crowbar_lo (crowbar_lo),
      .shutdown   (shutdown),
      .ss_restart (ss_restart)
   );

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic supply_low,
   input logic ot_hot,
   input logic ss_done,
   input logic pwr_good,
   input logic crowbar_lo,
   input logic shutdown,
   input logic ss_restart
);

   p_pg_needs_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> !shutdown);

   p_pg_needs_ss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> $past(ss_done));

   p_crowbar_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low |=> !crowbar_lo);

   p_ot_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ot_hot |=> shutdown);

   p_restart_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ss_restart |=> !ss_restart);

   p_restart_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ss_restart |-> !shutdown);

   p_disabled_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> shutdown);

   p_lockout_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low |=> shutdown);

endmodule

bind vfault_supervisor vfs_checker i_vfs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .supply_low (supply_low),
   .ot_hot     (ot_hot),
   .ss_done    (ss_done),
   .pwr_good   (pwr_good),
   .crowbar_lo (crowbar_lo),
   .shutdown   (shutdown),
   .ss_restart (ss_restart)
);

// File: tb/test_vfault_supervisor.sv
module test_vfault_supervisor;

   localparam int PERIOD  = 10;
   localparam int CLK_MHZ = 4;
   localparam int FILT_NS = 2000;
   localparam int NF      = (CLK_MHZ * FILT_NS + 999) / 1000;  // 8 clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, supply_low = 1'b0, ot_hot = 1'b0, ss_done = 1'b0;
   logic v75 = 1'b0, v90 = 1'b0, v110 = 1'b0, v120 = 1'b0;
   logic pwr_good, crowbar_lo, shutdown, ss_restart;

   int checks = 0;
   int errors = 0;
   int rs_seen = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   vfault_supervisor #(.CLK_MHZ(CLK_MHZ), .FILT_NS(FILT_NS)) i_vfault_supervisor (
      .clk(clk), .rst_n(rst_n), .en(en), .supply_low(supply_low), .ot_hot(ot_hot),
      .ss_done(ss_done), .v_below75(v75), .v_below90(v90), .v_above110(v110),
      .v_above120(v120), .pwr_good(pwr_good), .crowbar_lo(crowbar_lo),
      .shutdown(shutdown), .ss_restart(ss_restart)
   );

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: run lengths per flag and the resulting outputs
   int  run_len [4];
   bit  seen    [4];
   bit  m_latch, m_off, m_pg, m_cb, m_rs;

   always @(posedge clk or negedge rst_n) begin
      bit now[4];
      bit latch_next, off_next;
      if (!rst_n) begin
         foreach (run_len[i]) begin run_len[i] = 0; seen[i] = 1'b0; end
         m_latch = 1'b0; m_off = 1'b1; m_pg = 1'b0; m_cb = 1'b0; m_rs = 1'b0;
      end else begin
         now[0] = v75; now[1] = v90; now[2] = v110; now[3] = v120;
         if (!en || supply_low) latch_next = 1'b0;
         else latch_next = m_latch || (ss_done && !ot_hot && seen[0]);
         off_next = latch_next || ot_hot || supply_low || !en;
         m_rs    = m_off && !off_next;
         m_pg    = ss_done && !off_next && !seen[1] && !seen[2];
         m_cb    = seen[3] && !supply_low;
         m_off   = off_next;
         m_latch = latch_next;
         foreach (now[i]) begin
            if (now[i] != seen[i]) begin
               run_len[i]++;
               if (run_len[i] >= NF) begin seen[i] = now[i]; run_len[i] = 0; end
            end else run_len[i] = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 pwr_good vs model", pwr_good, m_pg);
         chk("R3 crowbar_lo vs model", crowbar_lo, m_cb);
         chk("R4 shutdown vs model", shutdown, m_off);
         chk("R8 ss_restart vs model", ss_restart, m_rs);
         if (ss_restart) rs_seen++;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #(PERIOD/4);
   endtask

   initial begin
      for (int c = 0; c < 5000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      chk("R9 reset shutdown", shutdown, 1'b1);
      chk("R9 reset pwr_good", pwr_good, 1'b0);
      chk("R9 reset crowbar", crowbar_lo, 1'b0);
      chk("R9 reset restart", ss_restart, 1'b0);
      rst_n = 1'b1;
      tick(2);
      chk("R10 off while disabled", shutdown, 1'b1);
      en = 1'b1;
      tick(2);
      chk("R10 on once enabled", shutdown, 1'b0);
      chk_int("R8 first restart pulse", rs_seen, 1);
      // below-75 during ramp must not latch
      v75 = 1'b1; tick(NF + 4);
      chk("R5 no latch before ss_done", shutdown, 1'b0);
      v75 = 1'b0; tick(NF + 4);
      ss_done = 1'b1; tick(2);
      chk("R2 power good in window", pwr_good, 1'b1);
      // short glitch on the 90 % flag
      v90 = 1'b1; tick(NF - 3); v90 = 1'b0; tick(NF + 2);
      chk("R1 glitch ignored", pwr_good, 1'b1);
      v90 = 1'b1; tick(NF + 2);
      chk("R2 low window drops pwr_good", pwr_good, 1'b0);
      v90 = 1'b0; tick(NF + 2);
      chk("R2 pwr_good restored", pwr_good, 1'b1);
      v110 = 1'b1; tick(NF + 2);
      chk("R2 high window drops pwr_good", pwr_good, 1'b0);
      v110 = 1'b0; tick(NF + 2);
      // soft crowbar
      v120 = 1'b1; tick(NF + 2);
      chk("R3 crowbar engaged", crowbar_lo, 1'b1);
      chk("R3 crowbar keeps running", shutdown, 1'b0);
      v120 = 1'b0; tick(NF + 2);
      chk("R3 crowbar released", crowbar_lo, 1'b0);
      // under-voltage latch
      v75 = 1'b1; tick(NF + 2);
      chk("R4 uv latches off", shutdown, 1'b1);
      chk("R4 pwr_good low on latch", pwr_good, 1'b0);
      v75 = 1'b0; ss_done = 1'b0; tick(NF + 4);
      chk("R4 latch holds", shutdown, 1'b1);
      en = 1'b0; tick(2);
      chk("R6 off while enable low", shutdown, 1'b1);
      en = 1'b1; tick(2);
      chk("R6 enable toggle clears latch", shutdown, 1'b0);
      chk_int("R8 restart after enable toggle", rs_seen, 2);
      ss_done = 1'b1;
      v75 = 1'b1; tick(NF + 2);
      chk("R4 uv latches again", shutdown, 1'b1);
      v75 = 1'b0; supply_low = 1'b1; tick(NF + 2);
      supply_low = 1'b0; tick(2);
      chk("R6 lockout cycle clears latch", shutdown, 1'b0);
      chk_int("R8 restart after lockout", rs_seen, 3);
      // thermal
      ot_hot = 1'b1; tick(2);
      chk("R7 thermal off", shutdown, 1'b1);
      chk("R7 pwr_good low when hot", pwr_good, 1'b0);
      ot_hot = 1'b0; tick(2);
      chk("R7 thermal recovery", shutdown, 1'b0);
      chk_int("R7 restart after thermal", rs_seen, 4);
      // lockout gates the crowbar
      supply_low = 1'b1; v120 = 1'b1; tick(NF + 2);
      chk("R3 crowbar gated by lockout", crowbar_lo, 1'b0);
      chk("R10 off under lockout", shutdown, 1'b1);
      supply_low = 1'b0; tick(2);
      chk("R3 crowbar after lockout", crowbar_lo, 1'b1);
      v120 = 1'b0; tick(NF + 2);
      chk_int("R8 restart count final", rs_seen, 5);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule